// File: doc/BRIEF.md
# Hashing-chip result frame receiver

This block sits behind a UART receiver and watches the received byte stream for the fixed-length result frames that a hashing chip sends back. Each frame starts with a two-byte sync pattern. A payload follows, carrying a nonce, a midstate number, a job tag, a partial version field and a checksum. The block takes the nonce, the job tag and the version field out of each complete frame. It turns the tag into an internal job index and looks that index up in an on-block job table, which holds a valid flag and a 32-bit base version for every job.

When the job is valid, the block emits a one-cycle result strobe. The strobe carries the job index, the nonce and the rolled version word. The rolled version is the byte-swapped 16-bit version field shifted up to bit 13 and merged with the job's base version. When the job is not valid, the block emits a one-cycle error strobe instead. Frames with a bad sync pattern produce neither strobe. Frames interrupted by a long idle gap also produce neither strobe.

Host logic fills the job table through a single write port. Each write sets a job's valid flag and base version together.

Top module: `result_frame_rx`

## Requirements
- R1: After reset both output strobes are low and every job table entry is invalid, so a frame for a job that was never written gives the error strobe.
- R2: A frame is 11 bytes: sync byte 0xAA, sync byte 0x55, then 9 payload bytes. The result for a frame appears in the cycle after the clock edge that accepts its last byte.
- R3: If the first sync byte is not 0xAA, or the byte after 0xAA is neither 0x55 nor 0xAA, the frame produces no strobe. The receiver keeps hunting and accepts the next good frame.
- R4: Inside a frame, an idle gap longer than `gap_limit` byte-times drops the partial frame and returns the receiver to sync hunting. One byte-time is `BYTE_CYCLES` clocks. A shorter gap is tolerated.
- R5: Payload bytes 0 to 3 form the nonce, with the first received byte in bits 7:0.
- R6: Payload byte 5 is the job tag. The job index is (tag AND 0xF0) shifted right by one, so the tag's low nibble is ignored.
- R7: A frame whose job entry is invalid gives a one-cycle `res_err` pulse and no `res_valid`. The two strobes are never high together.
- R8: Payload bytes 6 and 7 form the version field. The rolled version is ({byte6, byte7} << 13) OR the job's base version. Payload bytes 4 and 8 do not affect the outputs.
- R9: A table write sets both the valid flag and the base version of one index in a single cycle. A later frame for that index sees the new values.
- R10: A table write in the same cycle as the lookup for the same index takes priority, and the lookup returns the written values.
- R11: `res_valid` is a single-cycle pulse per accepted frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_byte | input | 8 | Received byte |
| gap_limit | input | GAP_W | Largest tolerated idle gap inside a frame, in byte-times |
| tbl_wr_en | input | 1 | Job table write strobe |
| tbl_wr_idx | input | 7 | Job index to write |
| tbl_wr_valid | input | 1 | Valid flag to store |
| tbl_wr_base | input | 32 | Base version to store |
| res_valid | output | 1 | Result strobe |
| res_idx | output | 7 | Job index of the result |
| res_nonce | output | 32 | Nonce of the result |
| res_version | output | 32 | Rolled version word |
| res_err | output | 1 | Strobe for a frame whose job entry is invalid |

## Verification
Two registers lie between the last byte of a frame and the outputs: the parser's frame strobe, then the result registers. `res_valid` or `res_err` is therefore due in the cycle after the edge that accepts the eleventh byte. Every byte is driven on a falling edge, and every result is sampled on the falling edge one clock after the final byte's edge. The next falling edge then confirms the strobe has dropped. The same-cycle write priority is exercised by raising the write on the falling edge just after the final byte, so the write lands on the lookup edge. Rejected and interrupted frames are checked with strobe counters sampled on falling edges, compared a few cycles after the frame ends.

// File: rtl/rfrx_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and types of the result frame receiver.
// Assumes one frame layout: two sync bytes followed by a fixed payload.
package rfrx_pkg;
    localparam int FRAME_BYTES    = 11;
    localparam int SYNC_BYTES     = 2;
    localparam int PAYLOAD_BYTES  = FRAME_BYTES - SYNC_BYTES;
    localparam int PAY_CNT_W      = $clog2(PAYLOAD_BYTES);
    localparam logic [7:0] SYNC_FIRST  = 8'hAA;
    localparam logic [7:0] SYNC_SECOND = 8'h55;

    localparam int NONCE_BYTES    = 4;
    localparam int NONCE_W        = 8 * NONCE_BYTES;
    localparam int NONCE_OFS      = 0;
    localparam int TAG_OFS        = 5;
    localparam int VER_OFS        = 6;
    localparam int VER_FIELD_W    = 16;

    localparam int JOB_ENTRIES    = 128;
    localparam int JOB_IDX_W      = $clog2(JOB_ENTRIES);
    localparam int BASE_W         = 32;
    localparam int VER_SHIFT      = 13;

    typedef enum logic [1:0] {
        PS_SYNC_A = 2'd0,
        PS_SYNC_B = 2'd1,
        PS_BODY   = 2'd2
    } parse_state_t;
endpackage

// File: rtl/rfrx_parser.sv
`timescale 1ns/1ps
// Frame parser: hunts for the two sync bytes, then collects the payload.
// It captures the nonce, the upper tag nibble and the version field, and
// pulses frame_valid for one cycle after the last payload byte.
// Assumes at most one byte per clock. Inside a frame, an idle gap longer than
// gap_limit byte-times (each BYTE_CYCLES clocks) drops the partial frame.
module rfrx_parser
    import rfrx_pkg::*;
#(
    parameter int BYTE_CYCLES = 16,
    parameter int GAP_W       = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rx_valid,
    input  logic [7:0]             rx_byte,
    input  logic [GAP_W-1:0]       gap_limit,
    output logic                   frame_valid,
    output logic [NONCE_W-1:0]     nonce,
    output logic [3:0]             tag_hi,
    output logic [VER_FIELD_W-1:0] ver_swapped
);
    localparam int CYC_W = $clog2(BYTE_CYCLES + 1);

    parse_state_t         state;
    logic [PAY_CNT_W-1:0] pay_cnt;
    logic [CYC_W-1:0]     idle_cyc;
    logic [GAP_W-1:0]     idle_bt;
    logic                 byte_time_done;

    // Marks the clock that completes one idle byte-time.
    assign byte_time_done = (idle_cyc == CYC_W'(BYTE_CYCLES - 1));

    // Sync hunting, payload counting, frame strobe and gap timeout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= PS_SYNC_A;
            pay_cnt     <= '0;
            frame_valid <= 1'b0;
            idle_cyc    <= '0;
            idle_bt     <= '0;
        end else begin
            frame_valid <= 1'b0;
            if (rx_valid) begin
                idle_cyc <= '0;
                idle_bt  <= '0;
                case (state)
                    PS_SYNC_A: begin
                        if (rx_byte == SYNC_FIRST) state <= PS_SYNC_B;
                    end
                    PS_SYNC_B: begin
                        if (rx_byte == SYNC_SECOND) begin
                            state   <= PS_BODY;
                            pay_cnt <= '0;
                        end else if (rx_byte != SYNC_FIRST) begin
                            state <= PS_SYNC_A;
                        end
                    end
                    PS_BODY: begin
                        pay_cnt <= pay_cnt + 1'b1;
                        if (pay_cnt == PAY_CNT_W'(PAYLOAD_BYTES - 1)) begin
                            frame_valid <= 1'b1;
                            state       <= PS_SYNC_A;
                        end
                    end
                    default: state <= PS_SYNC_A;
                endcase
            end else if (state != PS_SYNC_A) begin
                if (byte_time_done) begin
                    idle_cyc <= '0;
                    if (idle_bt == gap_limit) begin
                        idle_bt <= '0;
                        state   <= PS_SYNC_A;
                    end else begin
                        idle_bt <= idle_bt + 1'b1;
                    end
                end else begin
                    idle_cyc <= idle_cyc + 1'b1;
                end
            end else begin
                idle_cyc <= '0;
                idle_bt  <= '0;
            end
        end
    end

    // Captures the payload fields that the result path needs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nonce       <= '0;
            tag_hi      <= '0;
            ver_swapped <= '0;
        end else if (rx_valid && state == PS_BODY) begin
            for (int i = 0; i < NONCE_BYTES; i++) begin
                if (pay_cnt == PAY_CNT_W'(NONCE_OFS + i)) nonce[8*i +: 8] <= rx_byte;
            end
            if (pay_cnt == PAY_CNT_W'(TAG_OFS))     tag_hi           <= rx_byte[7:4];
            if (pay_cnt == PAY_CNT_W'(VER_OFS))     ver_swapped[15:8] <= rx_byte;
            if (pay_cnt == PAY_CNT_W'(VER_OFS + 1)) ver_swapped[7:0]  <= rx_byte;
        end
    end

    AST_FRAME_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> $past(rx_valid)); // R2
    AST_FRAME_BACK_TO_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> (state != PS_BODY)); // R2
endmodule

// File: rtl/rfrx_job_table.sv
`timescale 1ns/1ps
// Job table: one valid flag and one base version per job index.
// Reads are combinational. A write to the index being read in the same
// cycle is forwarded to the read outputs. Valid flags clear on reset.
// Base versions are plain storage and are not reset.
module rfrx_job_table
    import rfrx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [JOB_IDX_W-1:0] wr_idx,
    input  logic                 wr_valid,
    input  logic [BASE_W-1:0]    wr_base,
    input  logic [JOB_IDX_W-1:0] rd_idx,
    output logic                 rd_valid,
    output logic [BASE_W-1:0]    rd_base
);
    logic [JOB_ENTRIES-1:0] vld;
    logic [BASE_W-1:0]      base_mem [JOB_ENTRIES];
    logic                   fwd;

    // Stores the valid flags, cleared on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     vld         <= '0;
        else if (wr_en) vld[wr_idx] <= wr_valid;
    end

    // Stores the base versions.
    always_ff @(posedge clk) begin
        if (wr_en) base_mem[wr_idx] <= wr_base;
    end

    // Read with write forwarding for the same index.
    always_comb begin
        fwd      = wr_en && (wr_idx == rd_idx);
        rd_valid = fwd ? wr_valid : vld[rd_idx];
        rd_base  = fwd ? wr_base  : base_mem[rd_idx];
    end

    AST_WRITE_TAKES_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (vld[$past(wr_idx)] == $past(wr_valid))); // R9
endmodule

// File: rtl/rfrx_result_build.sv
`timescale 1ns/1ps
// Result builder: maps the tag nibble to a job index, looks the index up in
// the job table, and registers either a result strobe with the rolled version
// or an error strobe. Assumes frame_valid pulses for one cycle per frame.
module rfrx_result_build
    import rfrx_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   frame_valid,
    input  logic [NONCE_W-1:0]     nonce,
    input  logic [3:0]             tag_hi,
    input  logic [VER_FIELD_W-1:0] ver_swapped,
    output logic [JOB_IDX_W-1:0]   lk_idx,
    input  logic                   lk_valid,
    input  logic [BASE_W-1:0]      lk_base,
    output logic                   res_valid,
    output logic [JOB_IDX_W-1:0]   res_idx,
    output logic [NONCE_W-1:0]     res_nonce,
    output logic [BASE_W-1:0]      res_version,
    output logic                   res_err
);
    logic [7:0]        tag_masked;
    logic [BASE_W-1:0] rolled;

    // Derives the job index and the rolled version.
    always_comb begin
        tag_masked = {tag_hi, 4'h0};
        lk_idx     = JOB_IDX_W'(tag_masked >> 1);
        rolled     = (BASE_W'(ver_swapped) << VER_SHIFT) | lk_base;
    end

    // Registers the result or error strobe and the result fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid   <= 1'b0;
            res_err     <= 1'b0;
            res_idx     <= '0;
            res_nonce   <= '0;
            res_version <= '0;
        end else begin
            res_valid <= frame_valid && lk_valid;
            res_err   <= frame_valid && !lk_valid;
            if (frame_valid && lk_valid) begin
                res_idx     <= lk_idx;
                res_nonce   <= nonce;
                res_version <= rolled;
            end
        end
    end

    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_valid && res_err)); // R7
    AST_IDX_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_idx[2:0] == 3'b000)); // R6
    AST_OUT_FOLLOWS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid || res_err) |-> $past(frame_valid)); // R2
    AST_RESULT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid); // R11
endmodule

// File: rtl/result_frame_rx.sv
`timescale 1ns/1ps
// Top of the result frame receiver: parser, job table and result builder.
// Assumes a byte-wide receive stream with at most one byte per clock.
module result_frame_rx
    import rfrx_pkg::*;
#(
    parameter int BYTE_CYCLES = 16,
    parameter int GAP_W       = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_valid,
    input  logic [7:0]           rx_byte,
    input  logic [GAP_W-1:0]     gap_limit,
    input  logic                 tbl_wr_en,
    input  logic [JOB_IDX_W-1:0] tbl_wr_idx,
    input  logic                 tbl_wr_valid,
    input  logic [BASE_W-1:0]    tbl_wr_base,
    output logic                 res_valid,
    output logic [JOB_IDX_W-1:0] res_idx,
    output logic [NONCE_W-1:0]   res_nonce,
    output logic [BASE_W-1:0]    res_version,
    output logic                 res_err
);
    logic                   frame_valid;
    logic [NONCE_W-1:0]     f_nonce;
    logic [3:0]             f_tag_hi;
    logic [VER_FIELD_W-1:0] f_ver;
    logic [JOB_IDX_W-1:0]   lk_idx;
    logic                   lk_valid;
    logic [BASE_W-1:0]      lk_base;

    rfrx_parser #(.BYTE_CYCLES(BYTE_CYCLES), .GAP_W(GAP_W)) u_parser (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .gap_limit(gap_limit), .frame_valid(frame_valid), .nonce(f_nonce),
        .tag_hi(f_tag_hi), .ver_swapped(f_ver)
    );

    rfrx_job_table u_table (
        .clk(clk), .rst_n(rst_n), .wr_en(tbl_wr_en), .wr_idx(tbl_wr_idx),
        .wr_valid(tbl_wr_valid), .wr_base(tbl_wr_base), .rd_idx(lk_idx),
        .rd_valid(lk_valid), .rd_base(lk_base)
    );

    rfrx_result_build u_build (
        .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .nonce(f_nonce),
        .tag_hi(f_tag_hi), .ver_swapped(f_ver), .lk_idx(lk_idx),
        .lk_valid(lk_valid), .lk_base(lk_base), .res_valid(res_valid),
        .res_idx(res_idx), .res_nonce(res_nonce), .res_version(res_version),
        .res_err(res_err)
    );
endmodule

// File: tb/result_frame_rx_test.sv
`timescale 1ns/1ps
// Directed bench for the result frame receiver. Each scenario is one task.
module result_frame_rx_test;
    import rfrx_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic [7:0]  gap_limit = 8'd2;
    logic        tbl_wr_en = 1'b0;
    logic [6:0]  tbl_wr_idx = '0;
    logic        tbl_wr_valid = 1'b0;
    logic [31:0] tbl_wr_base = '0;
    logic        res_valid;
    logic [6:0]  res_idx;
    logic [31:0] res_nonce;
    logic [31:0] res_version;
    logic        res_err;

    int checks = 0;
    int errors = 0;
    int res_seen = 0;
    int err_seen = 0;
    bit done = 1'b0;
    logic [7:0] fr [FRAME_BYTES];

    result_frame_rx #(.BYTE_CYCLES(4), .GAP_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .gap_limit(gap_limit), .tbl_wr_en(tbl_wr_en), .tbl_wr_idx(tbl_wr_idx),
        .tbl_wr_valid(tbl_wr_valid), .tbl_wr_base(tbl_wr_base),
        .res_valid(res_valid), .res_idx(res_idx), .res_nonce(res_nonce),
        .res_version(res_version), .res_err(res_err)
    );

    always #5 clk = ~clk;

    always @(negedge clk) begin
        if (res_valid) res_seen++;
        if (res_err)   err_seen++;
    end

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic send_byte(logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_byte  = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic build(logic [7:0] s0, logic [7:0] s1, logic [31:0] nonce,
                         logic [7:0] mid, logic [7:0] tag, logic [7:0] v0,
                         logic [7:0] v1, logic [7:0] cs);
        fr[0] = s0;
        fr[1] = s1;
        for (int i = 0; i < 4; i++) fr[2+i] = nonce[8*i +: 8];
        fr[6] = mid;
        fr[7] = tag;
        fr[8] = v0;
        fr[9] = v1;
        fr[10] = cs;
    endtask

    task automatic send_range(int first, int last);
        for (int i = first; i <= last; i++) send_byte(fr[i]);
    endtask

    task automatic tbl_write(logic [6:0] idx, logic v, logic [31:0] base);
        @(negedge clk);
        tbl_wr_en = 1'b1; tbl_wr_idx = idx; tbl_wr_valid = v; tbl_wr_base = base;
        @(negedge clk);
        tbl_wr_en = 1'b0;
    endtask

    // Called right after the last byte: result is due one clock later.
    task automatic expect_result(string req, logic [6:0] idx, logic [31:0] nonce,
                                 logic [31:0] ver);
        @(negedge clk);
        check(req, "res_valid", 32'(res_valid), 32'd1);
        check(req, "res_err", 32'(res_err), 32'd0);
        check(req, "res_idx", 32'(res_idx), 32'(idx));
        check(req, "res_nonce", res_nonce, nonce);
        check(req, "res_version", res_version, ver);
        @(negedge clk);
        check("R11", "res_valid pulse width", 32'(res_valid), 32'd0);
    endtask

    task automatic expect_error(string req);
        @(negedge clk);
        check(req, "res_err", 32'(res_err), 32'd1);
        check(req, "res_valid", 32'(res_valid), 32'd0);
        @(negedge clk);
        check(req, "res_err pulse width", 32'(res_err), 32'd0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1", "res_valid after reset", 32'(res_valid), 32'd0);
        check("R1", "res_err after reset", 32'(res_err), 32'd0);
        build(8'hAA, 8'h55, 32'h01020304, 8'h00, 8'h30, 8'h00, 8'h00, 8'h00);
        send_range(0, 10);
        expect_error("R1 unwritten entry");
    endtask

    task automatic t_basic();
        tbl_write(7'h08, 1'b1, 32'h2000_0000);
        build(8'hAA, 8'h55, 32'h44332211, 8'h07, 8'h18, 8'h12, 8'h34, 8'h5A);
        send_range(0, 10);
        expect_result("R2 R5 R6 R8 R9", 7'h08, 32'h44332211, 32'h2246_8000);
    endtask

    task automatic t_top_index();
        tbl_write(7'h78, 1'b1, 32'h0000_0ABC);
        build(8'hAA, 8'h55, 32'hDEADBEEF, 8'h33, 8'hF7, 8'hFF, 8'hFF, 8'h01);
        send_range(0, 10);
        expect_result("R6 R8", 7'h78, 32'hDEADBEEF, 32'h1FFF_EABC);
    endtask

    task automatic t_invalidate();
        tbl_write(7'h08, 1'b0, 32'h0);
        build(8'hAA, 8'h55, 32'h44332211, 8'h07, 8'h18, 8'h12, 8'h34, 8'h5A);
        send_range(0, 10);
        expect_error("R7 R9 invalidated entry");
    endtask

    task automatic t_bad_sync();
        int r0;
        int e0;
        r0 = res_seen;
        e0 = err_seen;
        build(8'hAB, 8'h55, 32'hDEADBEEF, 8'h00, 8'hF0, 8'h00, 8'h01, 8'h00);
        send_range(0, 10);
        build(8'hAA, 8'h54, 32'hDEADBEEF, 8'h00, 8'hF0, 8'h00, 8'h01, 8'h00);
        send_range(0, 10);
        repeat (3) @(negedge clk);
        check("R3", "result pulses after bad sync", 32'(res_seen - r0), 32'd0);
        check("R3", "error pulses after bad sync", 32'(err_seen - e0), 32'd0);
        build(8'hAA, 8'h55, 32'hDEADBEEF, 8'h00, 8'hF0, 8'h00, 8'h01, 8'h00);
        send_range(0, 10);
        expect_result("R3 recovery", 7'h78, 32'hDEADBEEF, 32'h0000_2ABC);
    endtask

    task automatic t_gap();
        int r0;
        int e0;
        r0 = res_seen;
        e0 = err_seen;
        build(8'hAA, 8'h55, 32'hDEADBEEF, 8'h00, 8'hF0, 8'h00, 8'h02, 8'h00);
        send_range(0, 4);
        repeat (20) @(negedge clk);
        send_range(5, 10);
        repeat (3) @(negedge clk);
        check("R4", "result pulses after long gap", 32'(res_seen - r0), 32'd0);
        check("R4", "error pulses after long gap", 32'(err_seen - e0), 32'd0);
        send_range(0, 4);
        repeat (8) @(negedge clk);
        send_range(5, 10);
        expect_result("R4 short gap", 7'h78, 32'hDEADBEEF, 32'h0000_4ABC);
    endtask

    task automatic t_same_cycle_write();
        build(8'hAA, 8'h55, 32'hCAFE0102, 8'h00, 8'h20, 8'h00, 8'h00, 8'h00);
        send_range(0, 9);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_byte  = fr[10];
        @(negedge clk);
        rx_valid = 1'b0;
        tbl_wr_en = 1'b1; tbl_wr_idx = 7'h10; tbl_wr_valid = 1'b1; tbl_wr_base = 32'h5;
        @(negedge clk);
        tbl_wr_en = 1'b0;
        check("R10", "res_valid with forwarded write", 32'(res_valid), 32'd1);
        check("R10", "res_err with forwarded write", 32'(res_err), 32'd0);
        check("R10", "res_version with forwarded write", res_version, 32'h5);
        check("R10", "res_nonce", res_nonce, 32'hCAFE0102);
        build(8'hAA, 8'h55, 32'hCAFE0102, 8'h00, 8'h2F, 8'h00, 8'h01, 8'h77);
        send_range(0, 10);
        expect_result("R9 stored entry", 7'h10, 32'hCAFE0102, 32'h0000_2005);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_top_index();
        t_invalidate();
        t_bad_sync();
        t_gap();
        t_same_cycle_write();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule